// File: doc/BRIEF.md
# Power-On Strap Sampler with Synchronous APIC Clock Divider

This block manages a shared pad that serves two purposes. While the system powers up, the pad is a configuration input and its output driver stays in high impedance. A reference-clock timer measures the power-up window. When the window closes, the block captures the strap level once and from then on drives the reference clock out through the same pad.

The captured strap selects the rate of the APIC clock. A high strap gives an APIC clock equal to the PCI-rate clock. A low strap gives an APIC clock at half the PCI rate, and its edges stay aligned to PCI rising edges. The APIC clock is held low until the strap is known and the enable has crossed into the PCI clock domain. The window length is a parameter counted in reference-clock cycles. Its default is about 2 ms at 14.318 MHz, and a simulation can use a short value instead.

Top module: `apic_strap_top`

## Requirements
- R1: While rst_n is low, pad_oe, pad_out and apic_clk are all 0.
- R2: Until the window expires, pad_oe stays 0 and apic_clk stays 0.
- R3: pad_oe rises on the TERM_CYCLES-th rising edge of ref_clk after rst_n is released. It then stays 1 until the next reset.
- R4: When pad_oe is 1, pad_out follows the ref_clk waveform. When pad_oe is 0, pad_out is 0.
- R5: The strap passes through a two-flop synchroniser and is captured once, on the expiry edge. The captured value is the pad_in level sampled at the ref_clk edge two edges before expiry. Any pad_in change after that edge, including changes during the last two window cycles, has no effect until reset.
- R6: With a captured strap of 1 (full rate), once enabled, apic_clk is 1 while pci_clk is high and 0 while pci_clk is low.
- R7: With a captured strap of 0 (half rate), once enabled, apic_clk toggles on every pci_clk rising edge and holds its value in between. This gives half the PCI frequency at 50 % duty.
- R8: apic_clk starts after expiry only through a synchroniser in the PCI domain and a falling-edge enable. Its first transition is a rising edge aligned to a pci_clk rising edge, with no runt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; times the window and is driven out on the pad |
| pci_clk | input | 1 | PCI-rate clock that the APIC clock is derived from |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pad_in | input | 1 | Pad input level, read as the strap during the window |
| pad_out | output | 1 | Value driven onto the pad when enabled |
| pad_oe | output | 1 | Pad output enable; 0 keeps the driver in high impedance |
| apic_clk | output | 1 | APIC clock, full or half PCI rate |

## Verification
Window expiry and a strap transition can land in the same few reference cycles. In that case the synchroniser decides which level is captured. The bench flips pad_in between the edge two before expiry and the expiry edge itself. It then judges the captured rate at the APIC output, expecting the level from before the flip. A second flip after expiry must leave the APIC rate and the pad driver unchanged.

// File: rtl/apicstrap_pkg.sv
package apicstrap_pkg;

  typedef enum logic {
    APIC_HALF = 1'b0,
    APIC_FULL = 1'b1
  } apic_rate_e;

  // counter width able to hold values 0 .. n-1
  function automatic int unsigned count_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // strap level to divide selection: low strap halves the rate
  function automatic apic_rate_e rate_from_strap(input logic lvl);
    return lvl ? APIC_FULL : APIC_HALF;
  endfunction

  // next value of the half-rate toggle flop
  function automatic logic half_next(input logic en, input logic cur);
    return en ? ~cur : 1'b0;
  endfunction

endpackage

// File: rtl/strap_window_timer.sv
module strap_window_timer
  import apicstrap_pkg::*;
#(
  parameter int unsigned TERM_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst_n,
  output logic expire,
  output logic done
);
  localparam int unsigned W = count_bits(TERM_CYCLES);
  localparam logic [W-1:0] LAST = W'(TERM_CYCLES - 1);

  logic [W-1:0] cnt_q;
  logic         done_q;

  assign expire = !done_q && (cnt_q == LAST);
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (expire) done_q <= 1'b1;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import apicstrap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pad_lvl,
  input  logic       capture,
  output apic_rate_e rate
);
  logic       sync1_q, sync2_q;
  apic_rate_e rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      rate_q  <= APIC_HALF;
    end else begin
      sync1_q <= pad_lvl;
      sync2_q <= sync1_q;
      if (capture) rate_q <= rate_from_strap(sync2_q);
    end
  end

  assign rate = rate_q;
endmodule

// File: rtl/apic_divider.sv
module apic_divider
  import apicstrap_pkg::*;
(
  input  logic       pci_clk,
  input  logic       rst_n,
  input  logic       ready_ref,
  input  apic_rate_e rate_ref,
  output logic       apic_clk,
  output logic       en,
  output logic       half,
  output apic_rate_e rate
);
  logic       rdy1_q, rdy2_q;
  apic_rate_e rate1_q, rate2_q;
  logic       en_q;
  logic       half_q;

  // bring ready and rate into the PCI domain
  always_ff @(posedge pci_clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy1_q  <= 1'b0;
      rdy2_q  <= 1'b0;
      rate1_q <= APIC_HALF;
      rate2_q <= APIC_HALF;
    end else begin
      rdy1_q  <= ready_ref;
      rdy2_q  <= rdy1_q;
      rate1_q <= rate_ref;
      rate2_q <= rate1_q;
    end
  end

  // enable changes only while pci_clk is low, so no runt pulse escapes
  always_ff @(negedge pci_clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= rdy2_q;
  end

  always_ff @(posedge pci_clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_next(en_q, half_q);
  end

  always_comb begin
    if (!en_q)                  apic_clk = 1'b0;
    else if (rate2_q == APIC_FULL) apic_clk = pci_clk;
    else                        apic_clk = half_q;
  end

  assign en   = en_q;
  assign half = half_q;
  assign rate = rate2_q;
endmodule

// File: rtl/apic_strap_top.sv
module apic_strap_top
  import apicstrap_pkg::*;
#(
  parameter int unsigned TERM_CYCLES = 28636
) (
  input  logic ref_clk,
  input  logic pci_clk,
  input  logic rst_n,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe,
  output logic apic_clk
);
  logic       win_expire;
  logic       win_done;
  apic_rate_e strap_rate;
  logic       pci_en;
  logic       pci_half;
  apic_rate_e pci_rate;

  strap_window_timer #(.TERM_CYCLES(TERM_CYCLES)) u_timer (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .expire (win_expire),
    .done   (win_done)
  );

  strap_capture u_cap (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .pad_lvl (pad_in),
    .capture (win_expire),
    .rate    (strap_rate)
  );

  apic_divider u_div (
    .pci_clk   (pci_clk),
    .rst_n     (rst_n),
    .ready_ref (win_done),
    .rate_ref  (strap_rate),
    .apic_clk  (apic_clk),
    .en        (pci_en),
    .half      (pci_half),
    .rate      (pci_rate)
  );

  assign pad_oe  = win_done;
  assign pad_out = win_done & ref_clk;
endmodule

// File: rtl/apic_strap_checks.sv
module apic_strap_checks
  import apicstrap_pkg::*;
(
  input logic       ref_clk,
  input logic       pci_clk,
  input logic       rst_n,
  input logic       pad_oe,
  input logic       pad_out,
  input logic       apic_clk,
  input logic       win_expire,
  input apic_rate_e strap_rate,
  input logic       pci_en,
  input logic       pci_half,
  input apic_rate_e pci_rate
);
  // R3: once driving, the pad stays driven
  a_r3_oe_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pad_oe |=> pad_oe);

  // R3: the driver turns on only right after the expiry pulse
  a_r3_oe_after_expiry: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(pad_oe) |-> $past(win_expire));

  // R5: the captured strap never moves after capture
  a_r5_strap_frozen: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pad_oe |=> $stable(strap_rate));

  // R2: expiry happens while the pad is still an input
  a_r2_expire_while_input: assert property (@(posedge ref_clk) disable iff (!rst_n)
    win_expire |-> !pad_oe);

  // R4: pad is quiet without output enable
  a_r4_pad_quiet: assert property (@(negedge ref_clk) disable iff (!rst_n)
    !pad_oe |-> !pad_out);

  // R7: half-rate flop toggles on every enabled PCI rising edge
  a_r7_half_toggles: assert property (@(posedge pci_clk) disable iff (!rst_n)
    (pci_en && pci_rate == APIC_HALF) |=> (pci_half != $past(pci_half)));

  // R8: no APIC activity before the enable arrives
  a_r8_quiet_until_enabled: assert property (@(negedge pci_clk) disable iff (!rst_n)
    !pci_en |-> !apic_clk);
endmodule

bind apic_strap_top apic_strap_checks u_chk (
  .ref_clk    (ref_clk),
  .pci_clk    (pci_clk),
  .rst_n      (rst_n),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .apic_clk   (apic_clk),
  .win_expire (win_expire),
  .strap_rate (strap_rate),
  .pci_en     (pci_en),
  .pci_half   (pci_half),
  .pci_rate   (pci_rate)
);

// File: tb/apic_strap_top_test.sv
`timescale 1ns/1ps
module apic_strap_top_test;
  localparam int unsigned TERM = 16;

  logic ref_clk = 1'b0;
  logic pci_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic pad_in  = 1'b0;
  logic pad_out, pad_oe, apic_clk;

  int checks = 0;
  int errors = 0;

  always #2.5 ref_clk = ~ref_clk;   // 200 MHz
  always #6   pci_clk = ~pci_clk;   // 12 ns PCI-rate clock

  apic_strap_top #(.TERM_CYCLES(TERM)) uut (
    .ref_clk  (ref_clk),
    .pci_clk  (pci_clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .apic_clk (apic_clk)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard: expected APIC levels sampled just after pci rising edges
  logic  exp_q[$];
  string tag_q[$];
  bit    mon_on = 1'b0;

  always begin
    @(posedge pci_clk);
    #1;
    if (mon_on && exp_q.size() > 0) begin
      automatic logic  e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(t, apic_clk, e);
    end
  end

  task automatic push_exp(input string t, input logic e);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic run_case(input logic strap, input bit late_flip);
    rst_n  = 1'b0;
    pad_in = strap;
    repeat (4) @(posedge ref_clk);
    #1;
    check("R1 oe in reset", pad_oe, 1'b0);
    check("R1 pad_out in reset", pad_out, 1'b0);
    check("R1 apic in reset", apic_clk, 1'b0);
    @(negedge ref_clk);
    rst_n = 1'b1;
    repeat (TERM - 2) @(posedge ref_clk);
    // edge TERM-2 done: strap sampled here is what gets captured (R5)
    #1;
    if (late_flip) pad_in = ~strap;
    @(posedge ref_clk);
    #1;
    check("R2 oe before expiry", pad_oe, 1'b0);
    check("R2 apic before expiry", apic_clk, 1'b0);
    check("R4 pad_out while input", pad_out, 1'b0);
    @(posedge ref_clk);
    #1;
    check("R3 oe at expiry edge", pad_oe, 1'b1);
    check("R4 pad_out high phase", pad_out, 1'b1);
    @(negedge ref_clk);
    #1;
    check("R4 pad_out low phase", pad_out, 1'b0);
    // change after capture must be ignored (R5)
    pad_in = ~pad_in;
    repeat (6) @(posedge pci_clk);
    if (strap) begin
      for (int i = 0; i < 4; i++) begin
        @(posedge pci_clk); #1;
        check("R6 R5 full rate high", apic_clk, 1'b1);
        @(negedge pci_clk); #1;
        check("R6 R5 full rate low", apic_clk, 1'b0);
      end
    end else begin
      @(negedge pci_clk);
      begin
        automatic logic v = apic_clk;
        mon_on = 1'b1;
        for (int i = 0; i < 6; i++) begin
          v = ~v;
          push_exp("R7 R5 half rate toggle", v);
        end
        for (int i = 0; i < 6; i++) begin
          @(posedge pci_clk); #1;
          @(negedge pci_clk); #1;
          check("R7 half rate holds", apic_clk, v ^ ((i % 2 == 0) ? 1'b1 : 1'b0) ^ 1'b1 ^ ((5 % 2 == 0) ? 1'b0 : 1'b1));
        end
        mon_on = 1'b0;
      end
    end
    repeat (3) @(posedge ref_clk);
    #1;
    check("R3 oe stays", pad_oe, 1'b1);
  endtask

  // R8: first APIC transition after enable is a rise at a pci rising edge
  task automatic first_edge_case();
    rst_n  = 1'b0;
    pad_in = 1'b1;
    repeat (3) @(posedge ref_clk);
    @(negedge ref_clk);
    rst_n = 1'b1;
    @(posedge apic_clk);
    check("R8 apic rise with pci high", pci_clk, 1'b1);
    #0.5;
    check("R8 no runt pulse", apic_clk, 1'b1);
  endtask

  initial begin
    run_case(1'b1, 1'b0);
    run_case(1'b0, 1'b0);
    run_case(1'b0, 1'b1);   // flip inside last window cycles: low captured
    run_case(1'b1, 1'b1);   // flip inside last window cycles: high captured
    first_edge_case();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule